// File: doc/BRIEF.md
# System Tick Timer with Single Compare Channel

This block keeps a free-running tick count for the system and can raise one timed event. A 64-bit counter advances by one on every clock cycle in which the tick-enable input is high. That input is a single-cycle strobe derived from an external reference clock. Software reads the count as two 32-bit words. A consistent value comes from reading the upper word, then the lower word, then the upper word again, and retrying whenever the two upper-word reads differ. The counter carries from its low word into its high word in the same tick, so a rollover always shows up as a changed upper word.

One compare channel watches the low counter word. Software programs the compare register with the current low word plus a delta, which wraps modulo 2^32, and then sets the enable bit in the control/status register. On the tick where the low word reaches the compare value, a sticky match flag is set. The interrupt output is high while both the flag and the enable bit are set. Software clears the flag by writing 1 to its bit.

The register bus is a plain single-cycle interface with byte address, write strobe, write data and combinational read data.

Top module: `systick_timer`

## Requirements
- R1: After reset, every mapped register reads zero and the interrupt output is low.
- R2: The counter increases by exactly one on each clock edge where tick_en is high and holds its value on every other edge.
- R3: The low word (offset 0x04) wraps to zero on the same edge where the high word (offset 0x08) increments, so the value high*2^W+low always equals the number of applied ticks.
- R4: The compare register at offset 0x0C stores the full written word and reads it back unchanged.
- R5: With the enable bit (bit 4 at offset 0x00) set, the match flag (bit 0 at offset 0x00) is set on the tick edge where the low word becomes equal to the compare value. It then stays set until it is cleared.
- R6: With the enable bit clear, the low word passing the compare value leaves the match flag at zero.
- R7: A control write with bit 0 = 1 clears the match flag. A control write with bit 0 = 0 leaves the flag unchanged. Every control write loads bit 4 into the enable.
- R8: If a control write with bit 0 = 1 lands on the same edge as a new match, the flag ends up set.
- R9: The interrupt output equals the match flag ANDed with the enable bit, so clearing the enable bit masks the interrupt while the flag is kept.
- R10: Writes to offsets 0x04 and 0x08 leave the counter unchanged. Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C return zero, and writes there change nothing.
- R11: A compare value programmed as the current low word plus a delta D, with D from 6 up to the largest low-word value, produces the match after exactly D ticks and not earlier. The next match follows one full low-word period (2^W ticks) later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Single-cycle count strobe from the reference clock |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt, match flag AND enable |

## Verification
The bench runs the block with a narrow data width so that low-word rollover and the full compare range can be reached quickly. A gapped tick pattern, with idle cycles at a fixed stride and reads alternating between the two counter words across several carries, shows whether the carry into the upper word lands on the same edge as the low-word wrap. Compare deltas of the minimum, a middle value and the maximum separate an off-by-one match edge from a correct one, and waiting a full period after a match shows there are no extra matches. Single-edge overlaps of a clear write with a match, writes to the counter and unmapped offsets, and toggling enable while a flag is pending show the priority, ignore and masking rules.

// File: rtl/systick_pkg.sv
package systick_pkg;

   // Byte offsets decoded by software; kept fixed because drivers depend on them.
   localparam int unsigned OFF_CTRL   = 32'h0;
   localparam int unsigned OFF_CNT_LO = 32'h4;
   localparam int unsigned OFF_CNT_HI = 32'h8;
   localparam int unsigned OFF_CMP    = 32'hC;

   typedef enum logic [2:0] {
      SEL_CTRL,
      SEL_CNT_LO,
      SEL_CNT_HI,
      SEL_CMP,
      SEL_NONE
   } reg_sel_e;

endpackage

// File: rtl/systick_count.sv
module systick_count #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NWORDS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick_en,
   output logic [NWORDS*DATA_W-1:0] count_o,
   output logic [DATA_W-1:0]        lo_next_o
);

   localparam int unsigned CNT_W = NWORDS * DATA_W;

   // carry[w] is high when word w advances on this edge
   logic [NWORDS-1:0] carry;

   generate
      for (genvar w = 0; w < NWORDS; w++) begin : g_word
         logic [DATA_W-1:0] word_q;

         if (w == 0) begin : g_first
            assign carry[w] = tick_en;
         end else begin : g_rest
            assign carry[w] = carry[w-1] & (&count_o[(w-1)*DATA_W +: DATA_W]);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q <= '0;
            end else if (carry[w]) begin
               word_q <= word_q + DATA_W'(1);
            end
         end

         assign count_o[w*DATA_W +: DATA_W] = word_q;
      end
   endgenerate

   assign lo_next_o = count_o[DATA_W-1:0] + DATA_W'(1);

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> count_o == $past(count_o) + CNT_W'(1));

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(count_o));

   // R3
   carry_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && (&count_o[DATA_W-1:0])) |=>
         (count_o[DATA_W-1:0] == '0) &&
         (count_o[CNT_W-1:DATA_W] == $past(count_o[CNT_W-1:DATA_W]) + (CNT_W-DATA_W)'(1)));

endmodule

// File: rtl/systick_compare.sv
module systick_compare #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [DATA_W-1:0] lo_next_i,
   input  logic              cmp_wr_i,
   input  logic              ctrl_wr_i,
   input  logic [DATA_W-1:0] cmp_wdata_i,
   input  logic              en_wdata_i,
   input  logic              clr_wdata_i,
   output logic [DATA_W-1:0] cmp_o,
   output logic              en_o,
   output logic              flag_o,
   output logic              irq_o
);

   logic [DATA_W-1:0] cmp_q;
   logic              en_q;
   logic              flag_q;
   logic              match_hit;
   logic              clr_req;

   // Match is judged on the value the low word takes at this edge.
   assign match_hit = tick_en & en_q & (lo_next_i == cmp_q);
   assign clr_req   = ctrl_wr_i & clr_wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (cmp_wr_i) begin
         cmp_q <= cmp_wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (ctrl_wr_i) begin
         en_q <= en_wdata_i;
      end
   end

   // A new match outranks a clear arriving on the same edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (match_hit) begin
         flag_q <= 1'b1;
      end else if (clr_req) begin
         flag_q <= 1'b0;
      end
   end

   assign cmp_o  = cmp_q;
   assign en_o   = en_q;
   assign flag_o = flag_q;
   assign irq_o  = flag_q & en_q;

   // R5
   match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_hit |=> flag_o);

   // R5
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_req) |=> flag_o);

   // R6
   no_match_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_o && !flag_o) |=> !flag_o);

   // R7
   clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !match_hit) |=> !flag_o);

   // R8
   match_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && match_hit) |=> flag_o);

   // R4
   cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_wr_i |=> cmp_o == $past(cmp_wdata_i));

endmodule

// File: rtl/systick_decode.sv
module systick_decode
   import systick_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned FLAG_BIT = 0,
   parameter int unsigned EN_BIT   = 4
) (
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                wr_i,
   input  logic [2*DATA_W-1:0] count_i,
   input  logic [DATA_W-1:0]   cmp_i,
   input  logic                en_i,
   input  logic                flag_i,
   output logic                ctrl_wr_o,
   output logic                cmp_wr_o,
   output logic                cnt_wr_o,
   output logic [DATA_W-1:0]   rdata_o
);

   reg_sel_e sel;

   always_comb begin
      if (addr_i == ADDR_W'(OFF_CTRL)) begin
         sel = SEL_CTRL;
      end else if (addr_i == ADDR_W'(OFF_CNT_LO)) begin
         sel = SEL_CNT_LO;
      end else if (addr_i == ADDR_W'(OFF_CNT_HI)) begin
         sel = SEL_CNT_HI;
      end else if (addr_i == ADDR_W'(OFF_CMP)) begin
         sel = SEL_CMP;
      end else begin
         sel = SEL_NONE;
      end
   end

   assign ctrl_wr_o = wr_i && (sel == SEL_CTRL);
   assign cmp_wr_o  = wr_i && (sel == SEL_CMP);
   assign cnt_wr_o  = wr_i && ((sel == SEL_CNT_LO) || (sel == SEL_CNT_HI));

   always_comb begin
      rdata_o = '0;
      case (sel)
         SEL_CTRL: begin
            rdata_o[FLAG_BIT] = flag_i;
            rdata_o[EN_BIT]   = en_i;
         end
         SEL_CNT_LO: rdata_o = count_i[DATA_W-1:0];
         SEL_CNT_HI: rdata_o = count_i[2*DATA_W-1:DATA_W];
         SEL_CMP:    rdata_o = cmp_i;
         default:    rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/systick_timer.sv
module systick_timer #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned FLAG_BIT = 0,
   parameter int unsigned EN_BIT   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);

   localparam int unsigned NWORDS = 2;
   localparam int unsigned CNT_W  = NWORDS * DATA_W;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("systick_timer: DATA_W must be at least 8");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("systick_timer: ADDR_W must reach offset 0xC");
      end
      if ((EN_BIT >= DATA_W) || (FLAG_BIT >= DATA_W)) begin : g_bad_bits
         $error("systick_timer: control bit positions exceed DATA_W");
      end
      if (EN_BIT == FLAG_BIT) begin : g_bad_overlap
         $error("systick_timer: enable and flag bits must differ");
      end
   endgenerate

   logic [CNT_W-1:0]  count;
   logic [DATA_W-1:0] lo_next;
   logic [DATA_W-1:0] cmp_val;
   logic              en;
   logic              flag;
   logic              ctrl_wr;
   logic              cmp_wr;
   logic              cnt_wr;

   systick_count #(
      .DATA_W (DATA_W),
      .NWORDS (NWORDS)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .count_o   (count),
      .lo_next_o (lo_next)
   );

   systick_compare #(
      .DATA_W (DATA_W)
   ) u_compare (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_en     (tick_en),
      .lo_next_i   (lo_next),
      .cmp_wr_i    (cmp_wr),
      .ctrl_wr_i   (ctrl_wr),
      .cmp_wdata_i (bus_wdata),
      .en_wdata_i  (bus_wdata[EN_BIT]),
      .clr_wdata_i (bus_wdata[FLAG_BIT]),
      .cmp_o       (cmp_val),
      .en_o        (en),
      .flag_o      (flag),
      .irq_o       (irq)
   );

   systick_decode #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .FLAG_BIT (FLAG_BIT),
      .EN_BIT   (EN_BIT)
   ) u_decode (
      .addr_i    (bus_addr),
      .wr_i      (bus_wr),
      .count_i   (count),
      .cmp_i     (cmp_val),
      .en_i      (en),
      .flag_i    (flag),
      .ctrl_wr_o (ctrl_wr),
      .cmp_wr_o  (cmp_wr),
      .cnt_wr_o  (cnt_wr),
      .rdata_o   (bus_rdata)
   );

   // R10
   cnt_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && !tick_en) |=> $stable(count));

   // R10
   stray_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !ctrl_wr && !cmp_wr) |=> ($stable(cmp_val) && $stable(en)));

endmodule

// File: tb/systick_timer_bench.sv
module systick_timer_bench;

   localparam int W  = 8;
   localparam int AW = 8;
   localparam longint unsigned LOM  = (64'd1 << W) - 1;
   localparam longint unsigned CNTM = (64'd1 << (2*W)) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [W-1:0]  bus_wdata = '0;
   wire  [W-1:0]  bus_rdata;
   wire           irq;

   int n_cmp = 0;
   int n_bad = 0;

   longint unsigned m_cnt = 0;
   longint unsigned m_cmp = 0;
   bit              m_en = 1'b0;
   bit              m_flag = 1'b0;

   always #4 clk = ~clk;

   systick_timer #(
      .ADDR_W (AW),
      .DATA_W (W)
   ) u_systick_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   // Behavioural reference model, advanced on every edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_cmp = 0; m_en = 1'b0; m_flag = 1'b0;
      end else begin
         bit hit;
         hit = tick_en && m_en && (((m_cnt + 1) & LOM) == m_cmp);
         if (tick_en) m_cnt = (m_cnt + 1) & CNTM;
         if (bus_wr && bus_addr == 8'h0C) m_cmp = bus_wdata;
         if (bus_wr && bus_addr == 8'h00) begin
            if (bus_wdata[0]) m_flag = 1'b0;
            m_en = bus_wdata[4];
         end
         if (hit) m_flag = 1'b1;
      end
   end

   function automatic longint unsigned model_rd(input logic [AW-1:0] a);
      case (a)
         8'h00:   return (longint'(m_en) << 4) | longint'(m_flag);
         8'h04:   return m_cnt & LOM;
         8'h08:   return (m_cnt >> W) & LOM;
         8'h0C:   return m_cmp;
         default: return 0;
      endcase
   endfunction

   // Per-cycle comparison away from the active edge.
   always @(negedge clk) begin
      string tag;
      case (bus_addr)
         8'h00:   tag = "R5 ctrl";
         8'h04:   tag = "R2 lo";
         8'h08:   tag = "R3 hi";
         8'h0C:   tag = "R4 cmp";
         default: tag = "R10 unmapped";
      endcase
      chk(tag, bus_rdata, model_rd(bus_addr));
      chk("R9 irq", irq, m_flag & m_en);
   end

   task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
      @(posedge clk); #2;
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(posedge clk); #2;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
      @(posedge clk); #2;
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // Program a delta with the counter frozen, then release ticks.
   task automatic run_delta(input int d);
      logic [W-1:0] lo;
      tick_en = 1'b0;
      wr(8'h00, 8'h11);
      rd(8'h04, lo);
      wr(8'h0C, W'((lo + d) & LOM));
      @(posedge clk); #2;
      bus_addr = 8'h00;
      tick_en = 1'b1;
      repeat (d - 1) @(posedge clk);
      #2 chk("R11 no early match", bus_rdata[0], 0);
      @(posedge clk); #2;
      tick_en = 1'b0;
      chk("R11 match after delta", bus_rdata[0], 1);
      chk("R5 irq on match", irq, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R2 watchdog: actual=timeout expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [W-1:0] v, lo, hi;
      int n_ticks;

      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset values
      rd(8'h00, v); chk("R1 ctrl", v, 0);
      rd(8'h04, v); chk("R1 lo", v, 0);
      rd(8'h08, v); chk("R1 hi", v, 0);
      rd(8'h0C, v); chk("R1 cmp", v, 0);
      chk("R1 irq", irq, 0);

      // R2 / R3 gapped ticks across several carries
      n_ticks = 0;
      for (int i = 0; i < 700; i++) begin
         @(posedge clk); #2;
         tick_en = (i % 7) != 3;
         if (tick_en) n_ticks++;
         bus_addr = (i % 2) ? 8'h08 : 8'h04;
      end
      @(posedge clk); #2;
      tick_en = 1'b0;
      rd(8'h04, lo);
      rd(8'h08, hi);
      chk("R3 hi:lo equals tick count", (longint'(hi) << W) | lo, n_ticks);

      // R10 counter writes ignored, unmapped reads zero
      wr(8'h04, 8'hAA);
      wr(8'h08, 8'h55);
      rd(8'h04, v); chk("R10 lo after write", v, lo);
      rd(8'h08, v); chk("R10 hi after write", v, hi);
      wr(8'h0C, 8'h3C);
      wr(8'h10, 8'hFF);
      wr(8'h01, 8'hFF);
      rd(8'h0C, v); chk("R10 cmp after stray write", v, 8'h3C);
      rd(8'h00, v); chk("R10 ctrl after stray write", v, 0);
      rd(8'h01, v); chk("R10 unmapped 0x01", v, 0);
      rd(8'h10, v); chk("R10 unmapped 0x10", v, 0);
      rd(8'hFF, v); chk("R10 unmapped 0xFF", v, 0);

      // R4 compare readback
      wr(8'h0C, 8'hA5);
      rd(8'h0C, v); chk("R4 cmp readback", v, 8'hA5);

      // R6 disabled channel never matches
      wr(8'h00, 8'h01);
      rd(8'h04, lo);
      wr(8'h0C, W'((lo + 10) & LOM));
      tick_en = 1'b1;
      repeat (300) @(posedge clk);
      #2 tick_en = 1'b0;
      rd(8'h00, v); chk("R6 flag stays clear", v, 0);
      chk("R6 irq low", irq, 0);

      // R5 / R11 minimum, middle and maximum deltas
      run_delta(6);
      run_delta(37);
      run_delta(255);

      // R11 next match a full period later
      wr(8'h00, 8'h11);
      @(posedge clk); #2;
      bus_addr = 8'h00;
      tick_en = 1'b1;
      repeat (255) @(posedge clk);
      #2 chk("R11 no match within period", bus_rdata[0], 0);
      @(posedge clk); #2;
      tick_en = 1'b0;
      chk("R11 match after full period", bus_rdata[0], 1);

      // R7 clear semantics
      wr(8'h00, 8'h10);
      rd(8'h00, v); chk("R7 bit0=0 keeps flag", v[0], 1);
      wr(8'h00, 8'h11);
      rd(8'h00, v); chk("R7 bit0=1 clears flag", v[0], 0);

      // R8 clear and match on the same edge
      rd(8'h04, lo);
      wr(8'h0C, W'((lo + 1) & LOM));
      @(posedge clk); #2;
      tick_en = 1'b1;
      bus_addr = 8'h00; bus_wr = 1'b1; bus_wdata = 8'h11;
      @(posedge clk); #2;
      tick_en = 1'b0; bus_wr = 1'b0;
      chk("R8 match wins over clear", bus_rdata[0], 1);

      // R9 enable masks the interrupt, flag kept
      wr(8'h00, 8'h00);
      rd(8'h00, v);
      chk("R9 flag kept while disabled", v[0], 1);
      chk("R9 irq masked", irq, 0);
      wr(8'h00, 8'h10);
      #1 chk("R9 irq back on enable", irq, 1);

      repeat (4) @(posedge clk);
      summary();
      $finish;
   end

endmodule